// File: doc/BRIEF.md
# Power Bus Command Engine

This block lets a host processor run single-word read and write transactions on a narrow power-management bus. It has a small register file that the host reaches through a plain memory-mapped port. Each bus channel owns its own 32-byte window in that file. The window holds a command word, a word of outgoing data, a cycle budget for the reply and the word of returned data.

To run a transaction, the host loads the outgoing data if it is writing. It then writes the command word with the launch bit set. The command word packs the direction, the target device number and the word offset. The engine places one request toward the addressed slave, holds it until the slave takes it, and then waits for a reply. When the reply arrives, or the budget runs out, the launch bit drops. The host polls that bit and then reads the outcome: a timeout flag, a slave-error flag and, for a read, the returned word.

Each channel has its own state machine. The channels run independently and may be busy at the same time.

Top module: `pwrbus_cmd_engine`

## Requirements
- R1: After reset, every command word reads 0, outgoing data and returned data read 0, and the cycle budget reads TMO_RESET (default 256). Any host address outside the register windows reads 0.
- R2: Channel c's window begins at byte address 0xC0 + 0x20*c. Inside a window, the command word is at offset 0x0, outgoing data at 0x4, the cycle budget at 0x8 and returned data at 0xC. Returned data is read-only, so host writes to it have no effect. Read data appears on host_rdata, with host_rvalid high, in the cycle after host_re.
- R3: The command word has this layout: bit 31 launch/in-progress, bit 30 timeout flag, bit 29 slave-error flag, bit 28 busy, bits 27:21 always read 0, bit 20 direction (1 = write, 0 = read), bits 19:12 device number, bits 11:0 word offset.
- R4: When the host writes the command word with bit 31 set on an idle channel, bits 31 and 28 read 1 and both flags clear. Exactly one request is raised, carrying the direction, device, offset and the outgoing-data register. The request is held until the slave accepts it.
- R5: A reply that arrives after the request has been accepted ends the command, and bits 31 and 28 clear. For a read with no error, the returned-data register takes the reply word.
- R6: A reply with its error bit set raises the slave-error flag, which stays set until the next launch. The returned-data register keeps its old value.
- R7: With a cycle budget of T, a command that has had no reply by the (T+1)th clock edge after launch sets the timeout flag, clears bits 31 and 28 and drops the request. A reply that arrives later is ignored.
- R8: A reply that arrives on exactly the edge where the budget expires wins. The command completes normally and the timeout flag stays clear.
- R9: While a channel is busy, host writes to its command word, outgoing data and cycle budget have no effect.
- R10: The channels are independent. A command on one channel leaves the other channel's registers untouched, and both channels can be in flight at once.
- R11: A command-word write without bit 31 on an idle channel updates only the direction, device and offset. It leaves the flags unchanged and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe |
| host_addr | input | AW | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| host_rvalid | output | 1 | host_rdata valid, one cycle after host_re |
| req_valid | output | NCH | Per-channel request valid |
| req_ready | input | NCH | Per-channel slave accepts request |
| req_write | output | NCH | Per-channel direction, 1 = write |
| req_dev | output | NCH*8 | Per-channel device number |
| req_off | output | NCH*12 | Per-channel word offset |
| req_wdata | output | NCH*32 | Per-channel outgoing data |
| rsp_valid | input | NCH | Per-channel reply valid |
| rsp_rdata | input | NCH*32 | Per-channel reply data |
| rsp_err | input | NCH | Per-channel reply error |

## Verification
The case of interest is a slave reply and budget expiry landing on the same clock edge. It is set up by programming a budget of 5 and having the slave model answer exactly 5 cycles after it accepts the request, so the reply meets expiry on the sixth edge after launch. The bench expects a normal completion with the new read word and no timeout flag. It then repeats the run with a latency of 6, where it expects the timeout flag, the old returned word and a silently dropped late reply.

// File: rtl/pwrbus_pkg.sv
package pwrbus_pkg;
  localparam int DATA_W = 32;
  localparam int DEV_W  = 8;
  localparam int OFS_W  = 12;

  // command word bit positions
  localparam int BIT_GO   = 31;
  localparam int BIT_TMO  = 30;
  localparam int BIT_SERR = 29;
  localparam int BIT_BUSY = 28;
  localparam int BIT_DIR  = 20;
  localparam int DEV_LSB  = 12;

  // register index inside a window (byte offset / 4)
  localparam logic [1:0] IDX_CMD  = 2'd0;
  localparam logic [1:0] IDX_WDAT = 2'd1;
  localparam logic [1:0] IDX_BUDG = 2'd2;
  localparam logic [1:0] IDX_RDAT = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } fsm_st_t;
endpackage

// File: rtl/pwrbus_addr_dec.sv
module pwrbus_addr_dec #(
  parameter int AW        = 8,
  parameter int NCH       = 2,
  parameter int BASE      = 'hC0,
  parameter int WIN_BYTES = 32
) (
  input  logic [AW-1:0]  addr,
  output logic [NCH-1:0] ch_hit,
  output logic [1:0]     reg_idx
);
  localparam int WIN_LG = $clog2(WIN_BYTES);

  logic inner_ok;

  // only the four aligned words at the bottom of a window decode
  assign inner_ok = (addr[1:0] == 2'b00) && (addr[WIN_LG-1:4] == '0);
  assign reg_idx  = addr[3:2];

  for (genvar c = 0; c < NCH; c++) begin : g_win
    localparam logic [AW-1:0] WB = AW'(BASE + c * WIN_BYTES);
    assign ch_hit[c] = inner_ok && (addr[AW-1:WIN_LG] == WB[AW-1:WIN_LG]);
  end
endmodule

// File: rtl/pwrbus_chan_fsm.sv
module pwrbus_chan_fsm
  import pwrbus_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [CNT_W-1:0] limit,
  input  logic             req_ready,
  input  logic             rsp_valid,
  output logic             busy,
  output logic             req_valid,
  output logic             fin_rsp,
  output logic             fin_tmo
);
  fsm_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic             expire;

  assign expire  = (cnt >= limit);
  assign busy    = (st != ST_IDLE);
  // a reply beats expiry on the same edge
  assign fin_rsp = (st == ST_RSP) && rsp_valid;
  assign fin_tmo = expire && ((st == ST_REQ) || ((st == ST_RSP) && !rsp_valid));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      req_valid <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (launch) begin
            st        <= ST_REQ;
            req_valid <= 1'b1;
            cnt       <= '0;
          end
        end
        ST_REQ: begin
          if (expire) begin
            st        <= ST_IDLE;
            req_valid <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
            if (req_ready) begin
              st        <= ST_RSP;
              req_valid <= 1'b0;
            end
          end
        end
        ST_RSP: begin
          if (rsp_valid || expire) begin
            st <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          st        <= ST_IDLE;
          req_valid <= 1'b0;
        end
      endcase
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !expire) |=> req_valid);

  // R7
  tmo_drop_chk: assert property (@(posedge clk) disable iff (rst)
    fin_tmo |=> (!busy && !req_valid));

  // R5
  rsp_end_chk: assert property (@(posedge clk) disable iff (rst)
    fin_rsp |=> !busy);
endmodule

// File: rtl/pwrbus_chan.sv
module pwrbus_chan
  import pwrbus_pkg::*;
#(
  parameter int TMO_RESET = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic [1:0]        reg_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [DEV_W-1:0]  req_dev,
  output logic [OFS_W-1:0]  req_off,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  input  logic              rsp_err
);
  logic              dir_r;
  logic [DEV_W-1:0]  dev_r;
  logic [OFS_W-1:0]  off_r;
  logic              tmo_f;
  logic              serr_f;
  logic [DATA_W-1:0] wdat_r;
  logic [DATA_W-1:0] budg_r;
  logic [DATA_W-1:0] rdat_r;
  logic              busy;
  logic              fin_rsp;
  logic              fin_tmo;
  logic              cmd_wr;
  logic              launch;
  logic              host_wr;

  assign host_wr = we && sel && !busy;
  assign cmd_wr  = host_wr && (reg_idx == IDX_CMD);
  assign launch  = cmd_wr && wdata[BIT_GO];

  pwrbus_chan_fsm #(.CNT_W(DATA_W)) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .limit     (budg_r),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .busy      (busy),
    .req_valid (req_valid),
    .fin_rsp   (fin_rsp),
    .fin_tmo   (fin_tmo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_r  <= 1'b0;
      dev_r  <= '0;
      off_r  <= '0;
      tmo_f  <= 1'b0;
      serr_f <= 1'b0;
      wdat_r <= '0;
      budg_r <= DATA_W'(TMO_RESET);
      rdat_r <= '0;
    end else begin
      if (cmd_wr) begin
        dir_r <= wdata[BIT_DIR];
        dev_r <= wdata[DEV_LSB +: DEV_W];
        off_r <= wdata[OFS_W-1:0];
      end
      if (host_wr && (reg_idx == IDX_WDAT)) wdat_r <= wdata;
      if (host_wr && (reg_idx == IDX_BUDG)) budg_r <= wdata;

      if (launch) begin
        tmo_f  <= 1'b0;
        serr_f <= 1'b0;
      end else begin
        if (fin_tmo) tmo_f <= 1'b1;
        if (fin_rsp && rsp_err) serr_f <= 1'b1;
      end
      if (fin_rsp && !rsp_err && !dir_r) rdat_r <= rsp_rdata;
    end
  end

  always_comb begin
    case (reg_idx)
      IDX_CMD:  rd_word = {busy, tmo_f, serr_f, busy, 7'b0, dir_r, dev_r, off_r};
      IDX_WDAT: rd_word = wdat_r;
      IDX_BUDG: rd_word = budg_r;
      default:  rd_word = rdat_r;
    endcase
  end

  assign req_write = dir_r;
  assign req_dev   = dev_r;
  assign req_off   = off_r;
  assign req_wdata = wdat_r;

  // R9
  busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && we && sel) |=> ($stable(dev_r) && $stable(off_r) && $stable(wdat_r) && $stable(budg_r)));

  // R6
  serr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (fin_rsp && rsp_err) |=> ($stable(rdat_r) && serr_f));

  // R8
  rsp_no_tmo_chk: assert property (@(posedge clk) disable iff (rst)
    fin_rsp |=> !tmo_f);

  // R4
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> busy);
endmodule

// File: rtl/pwrbus_cmd_engine.sv
module pwrbus_cmd_engine
  import pwrbus_pkg::*;
#(
  parameter int AW        = 8,
  parameter int NCH       = 2,
  parameter int BASE      = 'hC0,
  parameter int WIN_BYTES = 32,
  parameter int TMO_RESET = 256
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  host_we,
  input  logic                  host_re,
  input  logic [AW-1:0]         host_addr,
  input  logic [31:0]           host_wdata,
  output logic [31:0]           host_rdata,
  output logic                  host_rvalid,
  output logic [NCH-1:0]        req_valid,
  input  logic [NCH-1:0]        req_ready,
  output logic [NCH-1:0]        req_write,
  output logic [NCH*DEV_W-1:0]  req_dev,
  output logic [NCH*OFS_W-1:0]  req_off,
  output logic [NCH*DATA_W-1:0] req_wdata,
  input  logic [NCH-1:0]        rsp_valid,
  input  logic [NCH*DATA_W-1:0] rsp_rdata,
  input  logic [NCH-1:0]        rsp_err
);
  logic [NCH-1:0]    ch_hit;
  logic [1:0]        reg_idx;
  logic [DATA_W-1:0] chan_word [NCH];
  logic [DATA_W-1:0] rd_mux;

  pwrbus_addr_dec #(
    .AW(AW), .NCH(NCH), .BASE(BASE), .WIN_BYTES(WIN_BYTES)
  ) dec_i (
    .addr    (host_addr),
    .ch_hit  (ch_hit),
    .reg_idx (reg_idx)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwrbus_chan #(.TMO_RESET(TMO_RESET)) chan_i (
      .clk       (clk),
      .rst       (rst),
      .sel       (ch_hit[c]),
      .we        (host_we),
      .reg_idx   (reg_idx),
      .wdata     (host_wdata),
      .rd_word   (chan_word[c]),
      .req_valid (req_valid[c]),
      .req_ready (req_ready[c]),
      .req_write (req_write[c]),
      .req_dev   (req_dev[c*DEV_W +: DEV_W]),
      .req_off   (req_off[c*OFS_W +: OFS_W]),
      .req_wdata (req_wdata[c*DATA_W +: DATA_W]),
      .rsp_valid (rsp_valid[c]),
      .rsp_rdata (rsp_rdata[c*DATA_W +: DATA_W]),
      .rsp_err   (rsp_err[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NCH; c++) begin
      if (ch_hit[c]) rd_mux = rd_mux | chan_word[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_re;
      if (host_re) host_rdata <= rd_mux;
    end
  end

  // R2
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> $past(host_re));

  // R2
  rvalid_onpulse_chk: assert property (@(posedge clk) disable iff (rst)
    host_re |=> host_rvalid);
endmodule

// File: tb/pwrbus_cmd_engine_tb.sv
module pwrbus_cmd_engine_tb_top;
  localparam int NCH = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              host_we = 1'b0;
  logic              host_re = 1'b0;
  logic [7:0]        host_addr = '0;
  logic [31:0]       host_wdata = '0;
  logic [31:0]       host_rdata;
  logic              host_rvalid;
  logic [NCH-1:0]    req_valid;
  logic [NCH-1:0]    req_ready = '1;
  logic [NCH-1:0]    req_write;
  logic [NCH*8-1:0]  req_dev;
  logic [NCH*12-1:0] req_off;
  logic [NCH*32-1:0] req_wdata;
  logic [NCH-1:0]    rsp_valid = '0;
  logic [NCH*32-1:0] rsp_rdata = '0;
  logic [NCH-1:0]    rsp_err = '0;

  always #4 clk = ~clk;

  pwrbus_cmd_engine dut_i (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_dev(req_dev), .req_off(req_off),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // per-channel slave model settings
  int          s_lat  [NCH];
  bit          s_mute [NCH];
  bit          s_err  [NCH];
  logic [31:0] s_data [NCH];

  // scoreboard: expected requests {write, dev, off, wdata}
  logic [52:0] exp_q0[$];
  logic [52:0] exp_q1[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] a_cmd(input int ch);  return 8'(8'hC0 + ch * 32);        endfunction
  function automatic logic [7:0] a_wdat(input int ch); return 8'(8'hC0 + ch * 32 + 4);    endfunction
  function automatic logic [7:0] a_budg(input int ch); return 8'(8'hC0 + ch * 32 + 8);    endfunction
  function automatic logic [7:0] a_rdat(input int ch); return 8'(8'hC0 + ch * 32 + 12);   endfunction

  function automatic logic [31:0] cw(input bit go, input bit wr, input logic [7:0] dev,
                                     input logic [11:0] off);
    return {go, 10'b0, wr, dev, off};
  endfunction

  task automatic hw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hr(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_re = 1'b1; host_addr = a;
    @(negedge clk);
    host_re = 1'b0;
    d = host_rdata;
  endtask

  task automatic poll(input int ch, output logic [31:0] d);
    for (int i = 0; i < 400; i++) begin
      hr(a_cmd(ch), d);
      if (!d[31]) break;
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic issue(input int ch, input bit wr, input logic [7:0] dev,
                       input logic [11:0] off, input logic [31:0] wd);
    hw(a_wdat(ch), wd);
    if (ch == 0) exp_q0.push_back({wr, dev, off, wd});
    else         exp_q1.push_back({wr, dev, off, wd});
    hw(a_cmd(ch), cw(1'b1, wr, dev, off));
  endtask

  task automatic slave_model(input int ch);
    logic [52:0] got;
    logic [52:0] want;
    forever begin
      @(negedge clk);
      if (req_valid[ch]) begin
        got = {req_write[ch], req_dev[ch*8 +: 8], req_off[ch*12 +: 12], req_wdata[ch*32 +: 32]};
        n_run++;
        if ((ch == 0 && exp_q0.size() == 0) || (ch == 1 && exp_q1.size() == 0)) begin
          n_fail++;
          $display("FAIL R4: unexpected request ch%0d actual %014h expected none", ch, got);
        end else begin
          want = (ch == 0) ? exp_q0.pop_front() : exp_q1.pop_front();
          if (got !== want) begin
            n_fail++;
            $display("FAIL R4: request ch%0d actual %014h expected %014h", ch, got, want);
          end
        end
        @(negedge clk);
        if (!s_mute[ch]) begin
          repeat (s_lat[ch] - 1) @(negedge clk);
          rsp_valid[ch] = 1'b1;
          rsp_err[ch] = s_err[ch];
          rsp_rdata[ch*32 +: 32] = s_data[ch];
          @(negedge clk);
          rsp_valid[ch] = 1'b0;
          rsp_err[ch] = 1'b0;
        end
      end
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [31:0] d;
    for (int c = 0; c < NCH; c++) begin
      s_lat[c] = 1; s_mute[c] = 0; s_err[c] = 0; s_data[c] = '0;
    end
    fork
      slave_model(0);
      slave_model(1);
    join_none
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    hr(a_cmd(0), d);  check("R1 cmd0", d, 32'h0);
    hr(a_cmd(1), d);  check("R1 cmd1", d, 32'h0);
    hr(a_budg(0), d); check("R1 budget0", d, 32'd256);
    hr(a_wdat(1), d); check("R1 wdata1", d, 32'h0);
    hr(a_rdat(1), d); check("R1 rdata1", d, 32'h0);
    hr(8'h10, d);     check("R1 outside window", d, 32'h0);

    // R2 map and read-only returned data
    hw(a_wdat(0), 32'hA5A5_5A5A);
    hr(a_wdat(0), d); check("R2 wdata0 readback", d, 32'hA5A5_5A5A);
    hw(a_budg(1), 32'd77);
    hr(a_budg(1), d); check("R2 budget1 readback", d, 32'd77);
    hw(a_rdat(0), 32'hCCCC_CCCC);
    hr(a_rdat(0), d); check("R2 rdata read-only", d, 32'h0);
    hr(a_budg(0), d); check("R10 budget0 untouched", d, 32'd256);

    // R3 / R11 command write without launch, reserved bits set
    hw(a_cmd(0), 32'h0FF0_0000 | cw(1'b0, 1'b1, 8'h3C, 12'h5A7));
    hr(a_cmd(0), d); check("R3 R11 cmd layout", d, cw(1'b0, 1'b1, 8'h3C, 12'h5A7));
    repeat (3) @(negedge clk);
    check("R11 no request", {31'b0, req_valid[0]}, 32'h0);

    // R4 / R5 write on channel 0
    s_lat[0] = 3;
    issue(0, 1'b1, 8'h21, 12'h044, 32'h1357_9BDF);
    hr(a_cmd(0), d); check("R4 go+busy set", d, 32'h9000_0000 | cw(1'b0, 1'b1, 8'h21, 12'h044));
    poll(0, d);      check("R5 write done", d, cw(1'b0, 1'b1, 8'h21, 12'h044));

    // R5 read on channel 1
    s_lat[1] = 3; s_data[1] = 32'hDEAD_BEEF;
    issue(1, 1'b0, 8'h07, 12'h010, 32'h0);
    poll(1, d);        check("R5 read done", d, cw(1'b0, 1'b0, 8'h07, 12'h010));
    hr(a_rdat(1), d);  check("R5 rdata1", d, 32'hDEAD_BEEF);
    hr(a_rdat(0), d);  check("R10 rdata0 untouched", d, 32'h0);

    // R6 slave error
    s_err[1] = 1; s_data[1] = 32'h5555_AAAA;
    issue(1, 1'b0, 8'h08, 12'h004, 32'h0);
    poll(1, d);        check("R6 serr flag", d, 32'h2000_0000 | cw(1'b0, 1'b0, 8'h08, 12'h004));
    hr(a_rdat(1), d);  check("R6 rdata kept", d, 32'hDEAD_BEEF);
    s_err[1] = 0;

    // R11 plain command write keeps flags
    hw(a_cmd(1), cw(1'b0, 1'b0, 8'h09, 12'h00C));
    hr(a_cmd(1), d); check("R11 flags kept", d, 32'h2000_0000 | cw(1'b0, 1'b0, 8'h09, 12'h00C));

    // R7 timeout with silent slave
    s_mute[0] = 1;
    hw(a_budg(0), 32'd8);
    issue(0, 1'b0, 8'h30, 12'h100, 32'h0);
    poll(0, d);      check("R7 timeout flag", d, 32'h4000_0000 | cw(1'b0, 1'b0, 8'h30, 12'h100));
    check("R7 request dropped", {31'b0, req_valid[0]}, 32'h0);
    s_mute[0] = 0;

    // R4 new launch clears flags
    s_lat[0] = 1;
    issue(0, 1'b1, 8'h31, 12'h101, 32'h0000_0042);
    poll(0, d);      check("R4 flags cleared", d, cw(1'b0, 1'b1, 8'h31, 12'h101));
    s_data[1] = 32'h0;
    issue(1, 1'b1, 8'h0A, 12'h002, 32'h0);
    poll(1, d);      check("R4 serr cleared", d, cw(1'b0, 1'b1, 8'h0A, 12'h002));

    // R8 reply on the expiry edge wins
    hw(a_budg(1), 32'd5);
    s_lat[1] = 5; s_data[1] = 32'h1234_5678;
    issue(1, 1'b0, 8'h0B, 12'h020, 32'h0);
    poll(1, d);       check("R8 no timeout", d, cw(1'b0, 1'b0, 8'h0B, 12'h020));
    hr(a_rdat(1), d); check("R8 rdata taken", d, 32'h1234_5678);
    // R7 one cycle later: expiry first, late reply dropped
    s_lat[1] = 6; s_data[1] = 32'h0BAD_F00D;
    issue(1, 1'b0, 8'h0C, 12'h021, 32'h0);
    poll(1, d);       check("R7 late reply timeout", d, 32'h4000_0000 | cw(1'b0, 1'b0, 8'h0C, 12'h021));
    hr(a_rdat(1), d); check("R7 late reply ignored", d, 32'h1234_5678);

    // R9 writes ignored while busy
    s_mute[0] = 1;
    hw(a_budg(0), 32'd40);
    issue(0, 1'b1, 8'h11, 12'h0AA, 32'h7777_0000);
    hw(a_cmd(0), cw(1'b1, 1'b0, 8'h22, 12'h0BB));
    hw(a_wdat(0), 32'h9999_9999);
    hw(a_budg(0), 32'd3);
    hr(a_cmd(0), d);  check("R9 cmd held", d, 32'h9000_0000 | cw(1'b0, 1'b1, 8'h11, 12'h0AA));
    hr(a_wdat(0), d); check("R9 wdata held", d, 32'h7777_0000);
    hr(a_budg(0), d); check("R9 budget held", d, 32'd40);
    poll(0, d);       check("R9 ends by timeout", d, 32'h4000_0000 | cw(1'b0, 1'b1, 8'h11, 12'h0AA));
    s_mute[0] = 0;

    // R10 both channels in flight
    hw(a_budg(1), 32'd200);
    s_lat[0] = 30; s_data[0] = 32'hAAAA_0001;
    s_lat[1] = 3;  s_data[1] = 32'hBBBB_0002;
    issue(0, 1'b0, 8'h40, 12'h001, 32'h0);
    issue(1, 1'b0, 8'h41, 12'h002, 32'h0);
    poll(1, d);       check("R10 ch1 done", d, cw(1'b0, 1'b0, 8'h41, 12'h002));
    hr(a_cmd(0), d);  check("R10 ch0 still busy", d, 32'h9000_0000 | cw(1'b0, 1'b0, 8'h40, 12'h001));
    poll(0, d);       check("R10 ch0 done", d, cw(1'b0, 1'b0, 8'h40, 12'h001));
    hr(a_rdat(0), d); check("R10 rdata0", d, 32'hAAAA_0001);
    hr(a_rdat(1), d); check("R10 rdata1", d, 32'hBBBB_0002);

    check("R4 all requests seen", 32'(exp_q0.size() + exp_q1.size()), 32'd0);
    summary();
  end
endmodule